// File: doc/BRIEF.md
# DMA Event Latch and Dispatcher

This block gathers transfer triggers for a bank of DMA channels and hands them, one at a time per queue, to a set of event queues. A trigger can come from three places: a rising edge on a peripheral's event line, a software write that sets event bits by hand, or a completion code returned by a finished transfer whose value names the channel to start next (chaining). All three merge into one pending-event register, one bit per channel.

A channel's pending bit is offered to the queue selected by that channel's queue-map field. Peripheral-sourced events are offered only while the channel's enable bit is set. Manual and chained triggers skip that gate. Each queue takes requests through a valid/ready handshake. Among the channels offered to one queue, the lowest channel number is offered first. An accepted event clears its pending bit.

Software writes can go out globally or through a shadow region. A shadow-region write is cut down to the channels that the region's access-enable mask allows. A peripheral edge that lands on a bit that is still pending is not lost silently; it sets a missed-event flag for that channel.

Top module: `dma_evt_dispatch`

## Requirements
- R1: A rising edge on `ext_evt[c]` sets pending bit `c` at the clock edge where the high level is first sampled. A level that stays high does not set the bit again.
- R2: A write with `wr_op`=0 (event set) sets the pending bit of every channel whose bit in the masked write data is one. Such a bit is offered to its queue whatever the enable bit holds.
- R3: A cycle with `cc_valid` high sets the pending bit of channel `cc_code`. That bit is offered whatever the enable bit holds.
- R4: A pending bit set only by a peripheral edge is offered to a queue only while its enable bit is one. `wr_op`=1 sets enable bits where the masked data is one, and `wr_op`=2 clears them there.
- R5: Each channel has a queue-map field, written by `wr_op`=4 with the channel in `wr_chan` and the queue index in the low bits of `wr_data`. A pending channel is offered only on `qreq_valid`/`qreq_chan` of its mapped queue.
- R6: `wr_op`=5 loads `wr_data` as the access-enable mask of region `wr_region`. When `wr_shadow` is 1, the data of ops 0 to 3 is ANDed with that region's mask. Shadow writes of ops 4 and 5 are ignored.
- R7: When several offered channels map to one queue, that queue presents the lowest channel number.
- R8: A pending bit clears at the edge where its queue has `qreq_valid` and `qreq_ready` both high for that channel. Without ready, the bit and the request are held.
- R9: A peripheral rising edge on a channel that is already pending, and not accepted in that cycle, sets `miss_mask` for that channel. `wr_op`=3 clears missed bits where the masked data is one.
- R10: After reset, the pending, enable, missed and access-enable masks are all zero, every channel maps to queue 0, and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt | input | NCH | Peripheral event lines, edge-detected |
| wr_valid | input | 1 | Software write strobe |
| wr_op | input | 3 | Write operation: 0 event set, 1 enable set, 2 enable clear, 3 missed clear, 4 queue map, 5 region mask |
| wr_shadow | input | 1 | 1 = write goes through the shadow region in `wr_region` |
| wr_region | input | RW | Region index |
| wr_chan | input | CW | Channel index for queue-map writes |
| wr_data | input | NCH | Write data / bit mask |
| cc_valid | input | 1 | Completion code valid |
| cc_code | input | CW | Completion code (channel to chain to) |
| qreq_ready | input | NQ | Per-queue accept |
| qreq_valid | output | NQ | Per-queue request valid |
| qreq_chan | output | NQ*CW | Per-queue offered channel, queue q in bits [q*CW +: CW] |
| evt_pend | output | NCH | Pending-event register |
| en_mask | output | NCH | Enable register |
| miss_mask | output | NCH | Missed-event flags |

## Verification
Every write, chain code and peripheral edge takes effect at the clock edge that samples it. The pending, enable and missed masks show the result right after that edge, and the queue request follows from them in the same cycle without an extra register. The bench therefore drives inputs just after a rising edge and reads the state just after the next one. The scoreboard monitor samples valid and ready at the falling edge, because the handshake completes at the following rising edge, so each expected grant is matched to the exact cycle in which it is accepted.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    typedef enum logic [2:0] {
        OP_EVT_SET  = 3'd0,
        OP_EN_SET   = 3'd1,
        OP_EN_CLR   = 3'd2,
        OP_MISS_CLR = 3'd3,
        OP_QMAP     = 3'd4,
        OP_RAE_WR   = 3'd5
    } wr_op_e;
endpackage

// File: rtl/dma_evt_edge.sv
module dma_evt_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dma_evt_pick.sv
module dma_evt_pick #(
    parameter int W  = 16,
    parameter int CW = 4
) (
    input  logic [W-1:0]  req,
    output logic          valid,
    output logic [CW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/dma_evt_dispatch.sv
module dma_evt_dispatch
    import dma_evt_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NREG = 2,
    parameter int NQ   = 2,
    localparam int CW  = (NCH  > 1) ? $clog2(NCH)  : 1,
    localparam int QW  = (NQ   > 1) ? $clog2(NQ)   : 1,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ext_evt,
    input  logic             wr_valid,
    input  logic [2:0]       wr_op,
    input  logic             wr_shadow,
    input  logic [RW-1:0]    wr_region,
    input  logic [CW-1:0]    wr_chan,
    input  logic [NCH-1:0]   wr_data,
    input  logic             cc_valid,
    input  logic [CW-1:0]    cc_code,
    input  logic [NQ-1:0]    qreq_ready,
    output logic [NQ-1:0]    qreq_valid,
    output logic [NQ*CW-1:0] qreq_chan,
    output logic [NCH-1:0]   evt_pend,
    output logic [NCH-1:0]   en_mask,
    output logic [NCH-1:0]   miss_mask
);
    typedef struct packed {
        logic [NCH-1:0]           evt;
        logic [NCH-1:0]           byp;
        logic [NCH-1:0]           en;
        logic [NCH-1:0]           miss;
        logic [NREG-1:0][NCH-1:0] rae;
        logic [NCH-1:0][QW-1:0]   qmap;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0]          rise;
    logic [NCH-1:0]          reg_mask;
    logic [NCH-1:0]          wmask;
    logic [NCH-1:0]          clr;
    logic [NQ-1:0][NCH-1:0]  elig;
    logic [NQ-1:0][CW-1:0]   pick_idx;
    logic [NQ-1:0][NCH-1:0]  grant_oh;

    wr_op_e op;
    assign op = wr_op_e'(wr_op);

    dma_evt_edge #(.W(NCH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ext_evt),
        .rise  (rise)
    );

    // one picker per queue over the channels mapped to it
    for (genvar q = 0; q < NQ; q++) begin : g_queue
        always_comb begin
            for (int c = 0; c < NCH; c++) begin
                elig[q][c] = st_q.evt[c] & (st_q.en[c] | st_q.byp[c])
                           & (st_q.qmap[c] == QW'(q));
            end
        end

        dma_evt_pick #(.W(NCH), .CW(CW)) u_pick (
            .req   (elig[q]),
            .valid (qreq_valid[q]),
            .idx   (pick_idx[q])
        );

        assign qreq_chan[q*CW +: CW] = pick_idx[q];
        assign grant_oh[q] = (qreq_valid[q] && qreq_ready[q])
                           ? (NCH'(1) << pick_idx[q]) : '0;

        // accepted channel leaves the pending set unless retriggered
        assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (qreq_valid[q] && qreq_ready[q] && !cc_valid && !wr_valid
             && !ext_evt[pick_idx[q]])
            |=> !evt_pend[$past(pick_idx[q])]);

        // an offered channel is enabled or was set by a bypassing source
        assert_offer_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
            qreq_valid[q] |-> (st_q.en[pick_idx[q]] || st_q.byp[pick_idx[q]]));
    end

    always_comb begin
        reg_mask = '0;
        if (int'(wr_region) < NREG) reg_mask = st_q.rae[wr_region];
        wmask = wr_shadow ? (wr_data & reg_mask) : wr_data;
    end

    always_comb begin
        logic [NCH-1:0] man;
        logic [NCH-1:0] chn;
        logic [NCH-1:0] mclr;

        clr = '0;
        for (int q = 0; q < NQ; q++) clr = clr | grant_oh[q];

        man  = (wr_valid && op == OP_EVT_SET)  ? wmask : '0;
        mclr = (wr_valid && op == OP_MISS_CLR) ? wmask : '0;
        chn  = cc_valid ? (NCH'(1) << cc_code) : '0;

        st_d      = st_q;
        st_d.evt  = (st_q.evt & ~clr) | rise | man | chn;
        st_d.byp  = (st_q.byp & ~clr) | man | chn;
        st_d.miss = (st_q.miss & ~mclr) | (rise & st_q.evt & ~clr);

        if (wr_valid) begin
            case (op)
                OP_EN_SET: st_d.en = st_q.en | wmask;
                OP_EN_CLR: st_d.en = st_q.en & ~wmask;
                OP_QMAP: begin
                    if (!wr_shadow && int'(wr_chan) < NCH)
                        st_d.qmap[wr_chan] = wr_data[QW-1:0];
                end
                OP_RAE_WR: begin
                    if (!wr_shadow && int'(wr_region) < NREG)
                        st_d.rae[wr_region] = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_pend  = st_q.evt;
    assign en_mask   = st_q.en;
    assign miss_mask = st_q.miss;

    assert_manual_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_op == 3'd0 && !wr_shadow)
        |=> ((evt_pend & $past(wr_data)) == $past(wr_data)));

    assert_chain_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |=> evt_pend[$past(cc_code)]);

    assert_shadow_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_op == 3'd1 && wr_shadow)
        |=> ((en_mask & ~$past(en_mask) & ~$past(reg_mask)) == '0));

    assert_miss_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_mask & ~$past(miss_mask) & ~$past(evt_pend)) == '0));
endmodule

// File: tb/tb_dma_evt_dispatch.sv
`timescale 1ns/1ps
module tb_dma_evt_dispatch;
    localparam int NCH = 16;
    localparam int NQ  = 2;
    localparam int CW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  ext_evt = '0;
    logic            wr_valid = 1'b0;
    logic [2:0]      wr_op = '0;
    logic            wr_shadow = 1'b0;
    logic            wr_region = 1'b0;
    logic [CW-1:0]   wr_chan = '0;
    logic [NCH-1:0]  wr_data = '0;
    logic            cc_valid = 1'b0;
    logic [CW-1:0]   cc_code = '0;
    logic [NQ-1:0]   qreq_ready = '0;
    logic [NQ-1:0]   qreq_valid;
    logic [NQ*CW-1:0] qreq_chan;
    logic [NCH-1:0]  evt_pend, en_mask, miss_mask;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    dma_evt_dispatch dut (
        .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt),
        .wr_valid(wr_valid), .wr_op(wr_op), .wr_shadow(wr_shadow),
        .wr_region(wr_region), .wr_chan(wr_chan), .wr_data(wr_data),
        .cc_valid(cc_valid), .cc_code(cc_code), .qreq_ready(qreq_ready),
        .qreq_valid(qreq_valid), .qreq_chan(qreq_chan),
        .evt_pend(evt_pend), .en_mask(en_mask), .miss_mask(miss_mask)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] op, logic sh, logic rg, logic [CW-1:0] ch,
                      logic [NCH-1:0] d);
        wr_valid = 1'b1; wr_op = op; wr_shadow = sh; wr_region = rg;
        wr_chan = ch; wr_data = d;
        cyc();
        wr_valid = 1'b0; wr_shadow = 1'b0;
    endtask

    task automatic expect_grant(int q, int ch);
        exp_q.push_back(q * 100 + ch);
    endtask

    task automatic drain(int q, int n);
        qreq_ready[q] = 1'b1;
        repeat (n) cyc();
        qreq_ready[q] = 1'b0;
    endtask

    // scoreboard monitor: handshake seen mid-cycle completes at next rising edge
    initial begin
        forever begin
            @(negedge clk);
            for (int q = 0; q < NQ; q++) begin
                if (rst_n && qreq_valid[q] && qreq_ready[q]) begin
                    int got;
                    got = q * 100 + int'(qreq_chan[q*CW +: CW]);
                    if (exp_q.size() == 0) check("R7 unexpected grant", got, 32'hFFFF);
                    else check("R7 R5 grant order", got, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R10 reset state
        check("R10 pend", evt_pend, 0);
        check("R10 en", en_mask, 0);
        check("R10 miss", miss_mask, 0);
        check("R10 valid", qreq_valid, 0);
        rst_n = 1'b1;
        cyc();

        // R6 region masks, R5 queue map
        wr(3'd5, 1'b0, 1'b0, 0, 16'h00FF);
        wr(3'd5, 1'b0, 1'b1, 0, 16'hFF00);
        wr(3'd4, 1'b0, 1'b0, 9, 16'h0001);
        wr(3'd4, 1'b0, 1'b0, 12, 16'h0001);

        // R1 / R4 peripheral edge without enable
        ext_evt[3] = 1'b1;
        cyc();
        check("R1 latched", evt_pend[3], 1);
        check("R4 not offered", qreq_valid[0], 0);
        wr(3'd1, 1'b0, 1'b0, 0, 16'h0008);
        check("R4 offered", qreq_valid[0], 1);
        check("R4 chan", qreq_chan[CW-1:0], 3);
        expect_grant(0, 3);
        drain(0, 1);
        check("R8 cleared", evt_pend[3], 0);
        cyc();
        check("R1 held level", evt_pend[3], 0);
        ext_evt[3] = 1'b0;
        cyc();

        // R2 manual set bypasses enable, R7 lowest first
        wr(3'd0, 1'b0, 1'b0, 0, 16'h0024);
        check("R2 pend", evt_pend, 16'h0024);
        check("R7 lowest", qreq_chan[CW-1:0], 2);
        expect_grant(0, 2);
        expect_grant(0, 5);
        drain(0, 2);
        check("R8 drained", evt_pend, 0);

        // R3 chain onto channel 9 mapped to queue 1
        cc_valid = 1'b1; cc_code = 4'd9;
        cyc();
        cc_valid = 1'b0;
        check("R3 pend", evt_pend[9], 1);
        check("R5 queue1 valid", qreq_valid, 2'b10);
        check("R5 queue1 chan", qreq_chan[2*CW-1:CW], 9);
        expect_grant(1, 9);
        drain(1, 1);

        // R6 shadow masking
        wr(3'd0, 1'b1, 1'b1, 0, 16'h00F0);
        check("R6 evt masked", evt_pend, 0);
        wr(3'd1, 1'b1, 1'b0, 0, 16'h0300);
        check("R6 en masked", en_mask, 16'h0008);
        wr(3'd1, 1'b1, 1'b1, 0, 16'h1200);
        check("R6 en passed", en_mask, 16'h1208);
        wr(3'd4, 1'b1, 1'b0, 3, 16'h0001);
        wr(3'd0, 1'b0, 1'b0, 0, 16'h0008);
        check("R6 shadow qmap ignored", qreq_valid, 2'b01);
        expect_grant(0, 3);
        drain(0, 1);

        // R4 enable clear
        wr(3'd2, 1'b0, 1'b0, 0, 16'h0008);
        check("R4 en cleared", en_mask, 16'h1200);
        ext_evt[3] = 1'b1;
        cyc();
        check("R4 gated", qreq_valid[0], 0);
        check("R4 still latched", evt_pend[3], 1);
        wr(3'd1, 1'b0, 1'b0, 0, 16'h0008);
        expect_grant(0, 3);
        drain(0, 1);
        ext_evt[3] = 1'b0;

        // R9 missed event
        ext_evt[12] = 1'b1;
        cyc();
        ext_evt[12] = 1'b0;
        cyc();
        check("R9 no miss yet", miss_mask, 0);
        ext_evt[12] = 1'b1;
        cyc();
        check("R9 miss set", miss_mask, 16'h1000);
        check("R8 held without ready", evt_pend[12], 1);
        wr(3'd3, 1'b1, 1'b0, 0, 16'h1000);
        check("R6 miss clear masked", miss_mask, 16'h1000);
        wr(3'd3, 1'b0, 1'b0, 0, 16'h1000);
        check("R9 miss cleared", miss_mask, 0);
        expect_grant(1, 12);
        drain(1, 1);
        ext_evt[12] = 1'b0;
        cyc();

        check("R8 all drained", evt_pend, 0);
        check("R7 scoreboard empty", exp_q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule